// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reset Request

This block guards a system against software that has stopped making progress. A clock prescaler divides the reference clock into a slow tick, and a watchdog counter advances once per tick. Software sets an expiry point in ticks and must write to a kick register before the counter reaches that point. If the count reaches the expiry point first, the block raises a system-reset request for a fixed number of reference-clock cycles, provided reset generation is enabled.

Software reaches the block through a word-addressed 32-bit register port with plain valid and write strobes. A control word holds four independent enables: prescaler, tick, counter and reset output. It also holds the prescaler terminal count. Writing zero to the control word stops the watchdog completely.

Top module: `wdog_timer`

## Requirements
- R1: Registers sit at byte offsets 0x0 (control), 0x4 (auxiliary control), 0x8 (timeout) and 0xC (kick). Reads of 0x0, 0x4 and 0x8 return the stored words. A read of 0xC returns the current counter. `rd_data` is zero when no read is in progress.
- R2: Control bit 25 enables the prescaler, bit 24 enables the tick, bit 21 enables the reset output, bit 18 enables the watchdog counter, and bits 17:0 hold the prescaler terminal count L. With bit 18 clear the counter does not advance.
- R3: While bits 25 and 24 are set, a tick occurs every L reference cycles, with L = 0 treated as 1. The counter advances by one on each tick while bit 18 is set.
- R4: The block can be fully restarted by a control write of zero, a kick, and then a control write with all enables set. After that restart, the reset request rises exactly T*L clock edges after the enabling control write, where T is the timeout.
- R5: The reset request stays high for exactly 16 reference-clock cycles.
- R6: After expiry the counter holds at the timeout value. No further request is raised until a kick or a control write.
- R7: A write of any data to 0xC clears both the counter and the prescaler. Kicks repeated faster than the timeout prevent any request.
- R8: With bit 21 clear, expiry halts the counter but raises no request.
- R9: Writing zero to the control word stops the watchdog. A pulse in progress ends on the next cycle, and no request follows.
- R10: Clearing bit 25 or bit 24 freezes the counter at its current value. Setting the bit again lets counting resume.
- R11: A timeout of zero never produces a request, and the counter stays put.
- R12: After reset all registers and the counter read zero and the request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| sys_rst_req | output | 1 | System-reset request pulse |

## Verification
The bench targets the exact expiry cycle for several prescaler and timeout pairs, including a terminal count of zero. A design with an off-by-one divider would raise the request a few edges early or late. It measures the pulse width and checks that the counter stays at the timeout afterwards; a design that re-armed itself would pulse repeatedly. Other checks cover a zero timeout, a cleared reset enable, frozen enables and a zero control write during a pulse. A wrong design would fire a request there, leave a pulse running, or keep counting while it should be frozen.

// File: rtl/wdog_pkg.sv
// Shared constants and the decoded view of the control word.
// Assumes a 32-bit register port; the bit positions are fixed because software decodes them.
package wdog_pkg;
    localparam int DATA_W     = 32;
    localparam int DIV_W      = 18;
    localparam int BIT_DIV_EN = 25;
    localparam int BIT_TCK_EN = 24;
    localparam int BIT_RST_EN = 21;
    localparam int BIT_CNT_EN = 18;

    localparam int WORD_CTRL = 0;
    localparam int WORD_AUX  = 1;
    localparam int WORD_TMO  = 2;
    localparam int WORD_KICK = 3;

    typedef struct packed {
        logic             div_en;
        logic             tick_en;
        logic             rst_en;
        logic             cnt_en;
        logic [DIV_W-1:0] div_load;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.div_en   = w[BIT_DIV_EN];
        c.tick_en  = w[BIT_TCK_EN];
        c.rst_en   = w[BIT_RST_EN];
        c.cnt_en   = w[BIT_CNT_EN];
        c.div_load = w[DIV_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/wdog_regs.sv
// Register file: decodes word addresses, stores control, auxiliary and timeout
// words, and produces single-cycle strobes for control writes and kicks.
// Assumes ADDR_W >= 4 and that a write and a read never share a cycle.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] cnt_in,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] tmo_q,
    output logic              ctrl_wr,
    output logic              kick,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  widx;
    logic [DATA_W-1:0] aux_q;
    logic              wr_en;
    logic              rd_en;
    logic              low_bits_unused;

    // Word index and access qualifiers.
    always_comb begin
        widx            = bus_addr[ADDR_W-1:2];
        low_bits_unused = ^bus_addr[1:0];
        wr_en           = bus_valid && bus_write;
        rd_en           = bus_valid && !bus_write;
        ctrl_wr         = wr_en && (widx == IDX_W'(WORD_CTRL));
        kick            = wr_en && (widx == IDX_W'(WORD_KICK));
    end

    // Storage for the writable words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            aux_q  <= '0;
            tmo_q  <= '0;
        end else if (wr_en) begin
            if (widx == IDX_W'(WORD_CTRL)) ctrl_q <= bus_wdata;
            if (widx == IDX_W'(WORD_AUX))  aux_q  <= bus_wdata;
            if (widx == IDX_W'(WORD_TMO))  tmo_q  <= bus_wdata;
        end
    end

    // Read multiplexer; zero when idle or unmapped.
    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            if (widx == IDX_W'(WORD_CTRL)) rd_data = ctrl_q;
            if (widx == IDX_W'(WORD_AUX))  rd_data = aux_q;
            if (widx == IDX_W'(WORD_TMO))  rd_data = tmo_q;
            if (widx == IDX_W'(WORD_KICK)) rd_data = cnt_in;
        end
    end

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_wr, kick}));
endmodule

// File: rtl/wdog_prescaler.sv
// Prescaler: emits a one-cycle tick every `load` cycles (load 0 acts as 1)
// while run is high, and holds its count while run is low.
// Assumes clear (a kick) has priority over running.
module wdog_prescaler #(
    parameter int DIV_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic [DIV_W-1:0] load,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] load_eff;

    // Terminal detection.
    always_comb begin
        load_eff = (load == '0) ? DIV_W'(1) : load;
        tick     = run && (div_cnt >= load_eff - DIV_W'(1));
    end

    // Divider count register.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_cnt <= '0;
        else if (clear)  div_cnt <= '0;
        else if (run)    div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
    end

    // R10
    div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(div_cnt));
endmodule

// File: rtl/wdog_counter.sv
// Watchdog counter and reset-pulse generator: counts ticks, halts at the timeout,
// and starts a PULSE_LEN-cycle request when reset output is enabled.
// Assumes kick and ctrl_wr are never high together.
module wdog_counter #(
    parameter int CNT_W     = 32,
    parameter int PULSE_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             count_en,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] tmo,
    input  logic             kick,
    input  logic             ctrl_wr,
    output logic [CNT_W-1:0] cnt,
    output logic             req
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [CNT_W:0]  cnt_inc;
    logic            armed;
    logic            expire;
    logic            halted;
    logic [PW-1:0]   pulse_left;
    logic [PW:0]     hi_len;

    // Arming and expiry detection.
    always_comb begin
        armed   = count_en && (tmo != '0) && !halted;
        cnt_inc = {1'b0, cnt} + (CNT_W + 1)'(1);
        expire  = tick && armed && (cnt_inc >= {1'b0, tmo});
        req     = (pulse_left != '0);
    end

    // Tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (kick)           cnt <= '0;
        else if (tick && armed)  cnt <= cnt_inc[CNT_W-1:0];
    end

    // Halt flag set at expiry, released by kick or control write.
    always_ff @(posedge clk) begin
        if (!rst_n)                 halted <= 1'b0;
        else if (kick || ctrl_wr)   halted <= 1'b0;
        else if (expire)            halted <= 1'b1;
    end

    // Reset-request pulse timer.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pulse_left <= '0;
        else if (ctrl_wr)            pulse_left <= '0;
        else if (expire && rst_en)   pulse_left <= PW'(PULSE_LEN);
        else if (pulse_left != '0)   pulse_left <= pulse_left - PW'(1);
    end

    // Checker-only run length of the request.
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_len <= '0;
        else if (req)  hi_len <= hi_len + (PW + 1)'(1);
        else           hi_len <= '0;
    end

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_len <= (PW + 1)'(PULSE_LEN));
    // R8
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> rst_en);
    // R11
    zero_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(tmo) != '0);
    // R6
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !kick && !ctrl_wr) |=> $stable(cnt));
    // R7
    kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> cnt == '0);
endmodule

// File: rtl/wdog_timer.sv
// Top level of the watchdog: register file, prescaler and counter.
// Assumes one reference clock and a synchronous active-low reset.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rd_data,
    output logic              sys_rst_req
);
    logic [DATA_W-1:0] ctrl_w;
    logic [DATA_W-1:0] tmo_w;
    logic [DATA_W-1:0] cnt_w;
    logic              ctrl_wr;
    logic              kick;
    logic              tick;
    logic              run;
    logic              count_en;
    ctrl_t             cfg;

    // Control decode and enable gating.
    always_comb begin
        cfg      = decode_ctrl(ctrl_w);
        run      = cfg.div_en && cfg.tick_en;
        count_en = run && cfg.cnt_en;
    end

    wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_in(cnt_w),
        .ctrl_q(ctrl_w), .tmo_q(tmo_w), .ctrl_wr(ctrl_wr), .kick(kick),
        .rd_data(rd_data)
    );

    wdog_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(kick),
        .load(cfg.div_load), .tick(tick)
    );

    wdog_counter #(.CNT_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(count_en),
        .rst_en(cfg.rst_en), .tmo(tmo_w), .kick(kick), .ctrl_wr(ctrl_wr),
        .cnt(cnt_w), .req(sys_rst_req)
    );

    // R9
    stop_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata == '0) |=> !sys_rst_req);
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    localparam int VEC_LOAD [NVEC] = '{3, 1, 5, 2, 0};
    localparam int VEC_TMO  [NVEC] = '{4, 5, 2, 1, 3};
    localparam int VEC_EXP  [NVEC] = '{12, 5, 10, 2, 3};

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_AUX  = 4'h4;
    localparam logic [3:0] A_TMO  = 4'h8;
    localparam logic [3:0] A_KICK = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        sys_rst_req;
    int          errors = 0;
    int          checks = 0;

    wdog_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .sys_rst_req(sys_rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] mk(input bit dv, input bit tk, input bit rs,
                                       input bit ce, input int ld);
        logic [31:0] w = '0;
        w[25] = dv; w[24] = tk; w[21] = rs; w[18] = ce;
        w[17:0] = ld[17:0];
        return w;
    endfunction

    task automatic check(input string req, input longint got, input longint exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        d = rd_data;
        bus_valid = 1'b0;
    endtask

    task automatic restart(input int ld, input int t, input bit rs);
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_TMO, t);
        bus_wr(A_KICK, 32'hDEAD_BEEF);
        bus_wr(A_CTRL, mk(1, 1, rs, 1, ld));
    endtask

    task automatic wait_req(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (sys_rst_req) return;
        end
        n = -1;
    endtask

    task automatic quiet(input int cyc, input string req);
        int seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (sys_rst_req) seen = 1;
        end
        check(req, seen, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d, c1, c2;
        int n, w;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R12 reset state
        check("R12 req", sys_rst_req, 0);
        bus_rd(A_CTRL, d); check("R12 ctrl", d, 0);
        bus_rd(A_TMO, d);  check("R12 tmo", d, 0);
        bus_rd(A_KICK, d); check("R12 cnt", d, 0);

        // R1 readback and idle read data
        bus_wr(A_AUX, 32'hA5A5_0F0F);
        bus_rd(A_AUX, d); check("R1 aux", d, 32'hA5A5_0F0F);
        bus_wr(A_TMO, 32'd777);
        bus_rd(A_TMO, d); check("R1 tmo", d, 777);
        @(negedge clk); check("R1 idle rdata", rd_data, 0);

        // R4 R5 R6 vector table: expiry cycle, pulse width, halt
        for (int v = 0; v < NVEC; v++) begin
            restart(VEC_LOAD[v], VEC_TMO[v], 1'b1);
            wait_req(200, n);
            check("R4 expiry edge", n, VEC_EXP[v]);
            w = 1;
            for (int k = 0; k < 40; k++) begin
                @(posedge clk); @(negedge clk);
                if (sys_rst_req) w++; else break;
            end
            check("R5 pulse width", w, 16);
            quiet(30, "R6 no repeat");
            bus_rd(A_KICK, d); check("R6 halted count", d, VEC_TMO[v]);
        end

        // R3 counter progress with L=4
        restart(4, 1000, 1'b1);
        repeat (10) @(posedge clk);
        bus_rd(A_KICK, d); check("R3 count after 10", d, 2);

        // R2 counter enable clear: no advance
        restart(1, 1000, 1'b1);
        bus_wr(A_CTRL, mk(1, 1, 1, 0, 1));
        bus_wr(A_KICK, 32'h0);
        repeat (20) @(posedge clk);
        bus_rd(A_KICK, d); check("R2 bit18 clear", d, 0);

        // R10 freeze via tick enable, then divider enable, then resume
        restart(2, 1000, 1'b1);
        repeat (9) @(posedge clk);
        bus_wr(A_CTRL, mk(1, 0, 1, 1, 2));
        bus_rd(A_KICK, c1);
        repeat (20) @(posedge clk);
        bus_rd(A_KICK, c2); check("R10 tick off frozen", c2, c1);
        bus_wr(A_CTRL, mk(0, 1, 1, 1, 2));
        repeat (20) @(posedge clk);
        bus_rd(A_KICK, c2); check("R10 div off frozen", c2, c1);
        bus_wr(A_CTRL, mk(1, 1, 1, 1, 2));
        repeat (10) @(posedge clk);
        bus_rd(A_KICK, c2); check("R10 resumes", c2 > c1, 1);

        // R7 kick data ignored, repeated kicks hold off expiry (expiry at 20)
        restart(2, 10, 1'b1);
        for (int k = 0; k < 6; k++) begin
            repeat (6) @(posedge clk);
            check("R7 no req while kicked", sys_rst_req, 0);
            bus_wr(A_KICK, k * 32'h1111_1111);
            bus_rd(A_KICK, d); check("R7 kick clears", d, 0);
        end

        // R8 reset output disabled
        restart(2, 3, 1'b0);
        quiet(30, "R8 no req");
        bus_rd(A_KICK, d); check("R8 halted", d, 3);

        // R11 zero timeout
        restart(1, 0, 1'b1);
        quiet(60, "R11 no req");
        bus_rd(A_KICK, d); check("R11 count", d, 0);

        // R9 zero control during a pulse
        restart(1, 2, 1'b1);
        wait_req(50, n);
        check("R9 pulse started", n, 2);
        bus_wr(A_CTRL, 32'h0);
        @(negedge clk); check("R9 pulse cut", sys_rst_req, 0);
        quiet(40, "R9 stays off");

        // R9 zero control before expiry
        restart(2, 10, 1'b1);
        repeat (5) @(posedge clk);
        bus_wr(A_CTRL, 32'h0);
        quiet(60, "R9 stopped");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule